// File: doc/BRIEF.md
# Serial Transmitter with Trailing-Bit Masking

This block shifts bytes out of an 8-bit synchronous shift register, most significant bit first. It advances by one bit for each cycle in which the shift-clock enable is high. Software hands bytes to a one-entry holding buffer. When a byte finishes and another byte is waiting, the next byte moves into the shift register at once, so the stream continues with no gap. The serial output is meant to drive a modulator.

Without masking, a telegram is always a whole number of bytes long. To send a telegram of any other length, software writes the last byte with `no_trim` low. This arms a 4-bit prescaler that counts shift clocks while that byte goes out. When the prescaler reaches the programmed compare value, the `mask` flag rises. From then on, every remaining bit of the byte is driven to 0. The telegram ends after that byte, and `eot` pulses.

The FSM has three states: `ST_OFF` (port deactivated), `ST_IDLE` (active, nothing shifting) and `ST_SHIFT` (a byte is in the shift register). The transitions are:
- OFF to IDLE when `halt` falls.
- IDLE to SHIFT (start) when the buffer is full.
- SHIFT to SHIFT (reload) at the end of a byte when another plain byte is buffered.
- SHIFT to IDLE (finish) at the end of a trimmed byte, or at the end of a byte when the buffer is empty.
- Any state to OFF while `halt` is high.

Top module: `trim_tx`

## Requirements
- R1: While shifting and active, `sdata` shows the current byte's bits most significant first. Each rising edge with `shift_en` high advances one bit. Without `shift_en`, `sdata` holds its value.
- R2: While `halt` is 1, the following apply from the next cycle:
  - `sdata`, `mask` and `eot` are 0.
  - The byte in progress is dropped.
  - A buffered byte stays in the buffer (`buf_empty` stays 0).
  - Two cycles after `halt` returns to 0, a buffered byte loads.
- R3: A byte written with `no_trim`=0 is a trimmed final word. Its first `cmp_val` bits (value sampled when the byte loads) go out unchanged. Its remaining bits go out as 0. A `cmp_val` of 8 or more sends the whole byte.
- R4: `mask` is 1 from bit index `cmp_val` of a trimmed word onward. If `cmp_val` is 0, `mask` is 1 from the load. `mask` never rises for bytes written with `no_trim`=1.
- R5: `eot` is a one-cycle pulse, visible in the cycle after the final word's eighth shift edge. The final word is either a trimmed word or a word that ends while the buffer is empty. No pulse appears between back-to-back bytes.
- R6: After a trimmed telegram, `mask` stays 1 until the next telegram starts or `halt` is asserted.
- R7: Buffer behaviour:
  - `buf_empty` is 1 after reset.
  - `buf_empty` is 0 from the cycle after a write.
  - `buf_empty` returns to 1 in the cycle after the byte moves into the shift register.
  - From IDLE, a byte loads on the edge after the buffer fills.
- R8: `sdata` is 0 whenever no byte is being shifted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Buffer write strobe |
| wr_data | input | 8 | Byte to buffer |
| no_trim | input | 1 | 1: plain byte; 0: trimmed final word |
| halt | input | 1 | 1 deactivates the port, 0 runs it |
| cmp_val | input | 4 | Count of unmasked bits in a trimmed word |
| shift_en | input | 1 | Shift-clock enable, one bit per high cycle |
| sdata | output | 1 | Serial data out |
| mask | output | 1 | Output-mask flag |
| buf_empty | output | 1 | Holding buffer empty |
| eot | output | 1 | End-of-telegram pulse |

## Verification
The hardest condition to reach from the ports is a deactivation that lands in the middle of a trimmed word after `mask` has already risen. In the same window, a plain byte must sit in the buffer; that byte must survive the deactivation and start a fresh, unmasked telegram afterwards. The stimulus gets there in stages:
- It loads a trimmed byte with a small compare value.
- It steps shift clocks one at a time until `mask` is seen high.
- It raises `halt`.
- While the port is off, it writes a plain byte and pulses `shift_en`.
- It releases `halt` and follows the new byte bit by bit.

// File: rtl/trim_tx_pkg.sv
package trim_tx_pkg;
    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_IDLE  = 2'd1,
        ST_SHIFT = 2'd2
    } tx_state_e;
endpackage

// File: rtl/trim_tx_hold.sv
// One-entry holding buffer; a write in the same cycle as a take wins.
module trim_tx_hold #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          wr_trim,
    input  logic          take,
    output logic          full,
    output logic [DW-1:0] data,
    output logic          trim
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full <= 1'b0;
            data <= '0;
            trim <= 1'b0;
        end else begin
            if (take) begin
                full <= 1'b0;
            end
            if (wr_en) begin
                full <= 1'b1;
                data <= wr_data;
                trim <= wr_trim;
            end
        end
    end
endmodule

// File: rtl/trim_tx_shreg.sv
// Shift register with bit counter and a tag marking a trimmed word.
module trim_tx_shreg #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          load,
    input  logic [DW-1:0] load_data,
    input  logic          load_tag,
    input  logic          adv,
    output logic          msb,
    output logic          last,
    output logic          tag
);
    localparam int CW = (DW > 1) ? $clog2(DW) : 1;

    logic [DW-1:0] sreg;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg <= '0;
            cnt  <= '0;
            tag  <= 1'b0;
        end else if (clear) begin
            sreg <= '0;
            cnt  <= '0;
            tag  <= 1'b0;
        end else if (load) begin
            sreg <= load_data;
            cnt  <= '0;
            tag  <= load_tag;
        end else if (adv) begin
            sreg <= {sreg[DW-2:0], 1'b0};
            cnt  <= cnt + 1'b1;
        end
    end

    assign msb  = sreg[DW-1];
    assign last = (cnt == CW'(DW - 1));
endmodule

// File: rtl/trim_tx_blank.sv
// Prescaler counting shift clocks of a trimmed word; raises the mask on compare.
module trim_tx_blank #(
    parameter int PW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          arm,
    input  logic [PW-1:0] cmp_in,
    input  logic          tick,
    output logic          mask
);
    logic          armed;
    logic [PW-1:0] cmp_q;
    logic [PW-1:0] pcnt;
    logic [PW-1:0] pnext;

    assign pnext = pcnt + 1'b1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
            cmp_q <= '0;
            pcnt  <= '0;
            mask  <= 1'b0;
        end else if (arm) begin
            armed <= 1'b1;
            cmp_q <= cmp_in;
            pcnt  <= '0;
            mask  <= (cmp_in == '0);
        end else if (clear) begin
            armed <= 1'b0;
            pcnt  <= '0;
            mask  <= 1'b0;
        end else if (tick && armed && !mask) begin
            pcnt <= pnext;
            if (pnext == cmp_q) begin
                mask <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/trim_tx.sv
module trim_tx #(
    parameter int DW = 8,
    parameter int PW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          no_trim,
    input  logic          halt,
    input  logic [PW-1:0] cmp_val,
    input  logic          shift_en,
    output logic          sdata,
    output logic          mask,
    output logic          buf_empty,
    output logic          eot
);
    import trim_tx_pkg::*;

    tx_state_e state_q, state_d;

    logic          hold_full, hold_trim;
    logic [DW-1:0] hold_data;
    logic          sh_msb, sh_last, sh_tag;
    logic          adv, byte_end, finish, start, reload, load;
    logic          mask_clr, mask_arm;

    trim_tx_hold #(.DW(DW)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .wr_trim (~no_trim),
        .take    (load),
        .full    (hold_full),
        .data    (hold_data),
        .trim    (hold_trim)
    );

    trim_tx_shreg #(.DW(DW)) u_shreg (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (halt),
        .load      (load),
        .load_data (hold_data),
        .load_tag  (hold_trim),
        .adv       (adv),
        .msb       (sh_msb),
        .last      (sh_last),
        .tag       (sh_tag)
    );

    trim_tx_blank #(.PW(PW)) u_blank (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (mask_clr),
        .arm    (mask_arm),
        .cmp_in (cmp_val),
        .tick   (adv),
        .mask   (mask)
    );

    // Event decode
    assign adv      = (state_q == ST_SHIFT) && shift_en && !halt;
    assign byte_end = adv && sh_last;
    assign finish   = byte_end && (sh_tag || !hold_full);
    assign start    = (state_q == ST_IDLE) && !halt && hold_full;
    assign reload   = byte_end && !sh_tag && hold_full;
    assign load     = start || reload;
    assign mask_arm = load && hold_trim;
    assign mask_clr = halt || (start && !hold_trim);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:   state_d = halt ? ST_OFF : ST_IDLE;
            ST_IDLE: begin
                if (halt)           state_d = ST_OFF;
                else if (hold_full) state_d = ST_SHIFT;
            end
            ST_SHIFT: begin
                if (halt)        state_d = ST_OFF;
                else if (finish) state_d = ST_IDLE;
            end
            default:  state_d = ST_OFF;
        endcase
    end

    // Outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eot <= 1'b0;
        end else begin
            eot <= finish;
        end
    end

    assign sdata     = (state_q == ST_SHIFT) && !mask && sh_msb;
    assign buf_empty = !hold_full;
endmodule

// File: rtl/trim_tx_chk.sv
module trim_tx_chk (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  halt,
    input logic                  shift_en,
    input logic                  wr_en,
    input logic                  sdata,
    input logic                  mask,
    input logic                  buf_empty,
    input logic                  eot,
    input trim_tx_pkg::tx_state_e state
);
    import trim_tx_pkg::*;

    a_r2_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> (!sdata && !mask && !eot));

    a_r1_hold_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT && !shift_en && !halt) |=> $stable(sdata));

    a_r6_mask_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (mask && state != ST_IDLE && !halt) |=> mask);

    a_r5_eot_single: assert property (@(posedge clk) disable iff (!rst_n)
        eot |=> !eot);

    a_r5_eot_after_shift: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eot) |-> $past(shift_en));

    a_r7_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !buf_empty);

    a_r8_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_SHIFT) |-> !sdata);
endmodule

bind trim_tx trim_tx_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .halt      (halt),
    .shift_en  (shift_en),
    .wr_en     (wr_en),
    .sdata     (sdata),
    .mask      (mask),
    .buf_empty (buf_empty),
    .eot       (eot),
    .state     (state_q)
);

// File: tb/sim_trim_tx.sv
`timescale 1ns/1ps
module sim_trim_tx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       no_trim = 1'b1;
    logic       halt = 1'b1;
    logic [3:0] cmp_val = '0;
    logic       shift_en = 1'b0;
    logic       sdata, mask, buf_empty, eot;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    trim_tx u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .no_trim(no_trim), .halt(halt), .cmp_val(cmp_val),
        .shift_en(shift_en), .sdata(sdata), .mask(mask),
        .buf_empty(buf_empty), .eot(eot)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic send(logic [7:0] b, logic trimmed);
        @(negedge clk);
        wr_en = 1'b1; wr_data = b; no_trim = !trimmed;
        @(negedge clk);
        wr_en = 1'b0; no_trim = 1'b1;
    endtask

    task automatic step_bit();
        @(negedge clk);
        shift_en = 1'b1;
        @(negedge clk);
        shift_en = 1'b0;
    endtask

    // Check and shift one byte; bits and mask predicted from R3/R4.
    task automatic follow(logic [7:0] b, logic trimmed, int cmp, string tag);
        for (int i = 0; i < 8; i++) begin
            logic blank;
            blank = trimmed && (i >= cmp);
            check({tag, " R1/R3 bit"}, sdata, blank ? 1'b0 : b[7-i]);
            check({tag, " R4 mask"}, mask, blank);
            step_bit();
        end
    endtask

    // Two-byte telegram: first byte plain, second byte optionally trimmed.
    task automatic t_telegram(logic [7:0] b0, logic [7:0] b1, logic t1, int cmp);
        cmp_val = cmp[3:0];
        send(b0, 1'b0);
        @(negedge clk);
        check("R7 empty after load", buf_empty, 1'b1);
        check("R6 mask cleared at start", mask, 1'b0);
        send(b1, t1);
        check("R7 empty falls on write", buf_empty, 1'b0);
        follow(b0, 1'b0, cmp, "first");
        check("R5 no eot between bytes", eot, 1'b0);
        check("R7 reload empties buffer", buf_empty, 1'b1);
        follow(b1, t1, cmp, "last");
        check("R5 eot pulse", eot, 1'b1);
        @(negedge clk);
        check("R5 eot one cycle", eot, 1'b0);
        check("R8 idle low", sdata, 1'b0);
        check("R6 mask persists", mask, t1 && (cmp < 8));
    endtask

    task automatic t_hold_bit();
        cmp_val = 4'd8;
        send(8'h80, 1'b0);
        @(negedge clk);
        repeat (4) begin
            @(negedge clk);
            check("R1 hold without shift_en", sdata, 1'b1);
        end
        follow(8'h80, 1'b0, 8, "hold");
        check("R5 eot after underrun", eot, 1'b1);
        @(negedge clk);
    endtask

    task automatic t_off_mid();
        cmp_val = 4'd2;
        send(8'hFF, 1'b1);
        @(negedge clk);
        step_bit();
        step_bit();
        check("R4 mask at bit two", mask, 1'b1);
        check("R3 blanked bit", sdata, 1'b0);
        halt = 1'b1;
        @(negedge clk);
        check("R2 mask cleared by halt", mask, 1'b0);
        check("R2 sdata low when off", sdata, 1'b0);
        send(8'h81, 1'b0);
        repeat (3) begin
            step_bit();
            check("R2 buffer kept while off", buf_empty, 1'b0);
            check("R2 no eot while off", eot, 1'b0);
            check("R2 sdata low when off", sdata, 1'b0);
        end
        @(negedge clk);
        halt = 1'b0;
        @(negedge clk);
        check("R2 not loaded after one cycle", buf_empty, 1'b0);
        @(negedge clk);
        check("R2 loads after resume", buf_empty, 1'b1);
        follow(8'h81, 1'b0, 2, "resume");
        check("R5 eot after resume", eot, 1'b1);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R7 reset empty", buf_empty, 1'b1);
        check("R8 reset sdata", sdata, 1'b0);
        check("R4 reset mask", mask, 1'b0);
        check("R5 reset eot", eot, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        halt = 1'b0;
        @(negedge clk);
        t_telegram(8'hA5, 8'h3C, 1'b0, 3);   // plain, R4 no mask without trim
        t_telegram(8'h5A, 8'hF7, 1'b1, 3);   // trimmed to 3 bits
        t_telegram(8'hC3, 8'hFF, 1'b1, 0);   // everything blanked
        t_telegram(8'h96, 8'hE1, 1'b1, 10);  // compare beyond byte
        t_telegram(8'h0F, 8'hB6, 1'b1, 7);
        t_hold_bit();
        t_off_mid();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule